// File: doc/BRIEF.md
# Immediate Add and Subtract-From Unit

This block is a 64-bit integer execution unit for three immediate-form operations. It takes a register operand, a 16-bit signed immediate and a 2-bit operation code. It can add the immediate to the operand, add the immediate moved up by 16 bit positions, or subtract the operand from the immediate. All results wrap modulo 2^64. One adder serves all three operations. It is split at the word midpoint, so a single subtraction yields two carries at once: one out of bit 31 and one out of bit 63.

The unit accepts one operation per clock and presents the result one clock later with an output strobe. The output register works in two named conditions. In CAPTURE, the input strobe is high and new values are loaded. In HOLD, the strobe is low and the last values stay unchanged. Only the subtract form is allowed to change the carry state. The unit reports this through a carry write-enable. The operation codes are ADD_IMM (00), ADD_SHIFTED (01), SUB_FROM (10) and RESERVED (11).

Top module: `imm_alu`

## Requirements
- R1: Code 00 gives result = operand + sign-extended immediate, modulo 2^64.
- R2: Code 01 gives result = operand + (sign-extended immediate shifted left by 16), modulo 2^64. The sign is extended before the shift.
- R3: Code 10 gives result = (bitwise inverse of operand) + sign-extended immediate + 1, modulo 2^64. This equals immediate minus operand.
- R4: For code 10, carry bit 0 is the carry out of bit 63 of the unsigned sum in R3.
- R5: For code 10, carry bit 1 is the carry out of bit 31 of the sum of the low 32 bits of the inverted operand, the low 32 bits of the extended immediate, and 1.
- R6: For codes 00 and 01, carry is 00 and carry_we is 0. For code 10, carry_we is 1.
- R7: Code 11 gives result 0, carry 00 and carry_we 0.
- R8: out_valid equals in_valid delayed by exactly one clock. When in_valid is low, result, carry and carry_we keep their previous values.
- R9: A synchronous active-high reset clears out_valid, result, carry and carry_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 2 | Operation code (00, 01, 10, 11) |
| reg_a | input | 64 | Register operand |
| imm | input | 16 | Signed immediate |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| result | output | 64 | Registered result |
| carry | output | 2 | Bit 0: carry out of bit 63; bit 1: carry out of bit 31 |
| carry_we | output | 1 | High when the carry field is to be written |

## Verification
The two carries come from one subtraction in the same cycle, so the bench must tell them apart. It drives operand and immediate pairs where only the bit-31 carry is set, where only the bit-63 carry is set, where both are set and where neither is set. A scoreboard computes each expected pair from full-width sums and compares both bits together with the result. Operands 0 and all-ones, and immediates 0, -32768 and 32767, also exercise the sign-extension edges under all four codes.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;
    typedef enum logic [1:0] {
        OP_ADD_IMM     = 2'b00,
        OP_ADD_SHIFTED = 2'b01,
        OP_SUB_FROM    = 2'b10,
        OP_RESERVED    = 2'b11
    } op_e;
endpackage

// File: rtl/imm_operand_gen.sv
module imm_operand_gen
    import imm_alu_pkg::*;
#(
    parameter int W  = 64,
    parameter int IW = 16,
    parameter int SH = 16
) (
    input  logic [1:0]    op_sel,
    input  logic [W-1:0]  reg_a,
    input  logic [IW-1:0] imm,
    output logic [W-1:0]  opnd_x,
    output logic [W-1:0]  opnd_y,
    output logic          carry_in,
    output logic          wr_carry
);
    localparam int EXT_PLAIN = W - IW;
    localparam int EXT_SHIFT = W - IW - SH;

    logic [W-1:0] imm_plain;
    logic [W-1:0] imm_shifted;

    assign imm_plain   = {{EXT_PLAIN{imm[IW-1]}}, imm};
    assign imm_shifted = {{EXT_SHIFT{imm[IW-1]}}, imm, {SH{1'b0}}};

    always_comb begin
        opnd_x   = '0;
        opnd_y   = '0;
        carry_in = 1'b0;
        wr_carry = 1'b0;
        unique case (op_e'(op_sel))
            OP_ADD_IMM: begin
                opnd_x = reg_a;
                opnd_y = imm_plain;
            end
            OP_ADD_SHIFTED: begin
                opnd_x = reg_a;
                opnd_y = imm_shifted;
            end
            OP_SUB_FROM: begin
                opnd_x   = ~reg_a;
                opnd_y   = imm_plain;
                carry_in = 1'b1;
                wr_carry = 1'b1;
            end
            OP_RESERVED: begin
                opnd_x = '0;
                opnd_y = '0;
            end
        endcase
    end
endmodule

// File: rtl/split_adder.sv
module split_adder #(
    parameter int W    = 64,
    parameter int HALF = W / 2
) (
    input  logic [W-1:0] opnd_x,
    input  logic [W-1:0] opnd_y,
    input  logic         carry_in,
    output logic [W-1:0] sum,
    output logic         carry_mid,
    output logic         carry_top
);
    localparam int UPPER = W - HALF;

    logic [HALF:0]  low_sum;
    logic [UPPER:0] high_sum;

    // Low half takes the incoming carry; its carry-out feeds the high half.
    assign low_sum  = {1'b0, opnd_x[HALF-1:0]} + {1'b0, opnd_y[HALF-1:0]}
                    + {{HALF{1'b0}}, carry_in};
    assign high_sum = {1'b0, opnd_x[W-1:HALF]} + {1'b0, opnd_y[W-1:HALF]}
                    + {{UPPER{1'b0}}, low_sum[HALF]};

    assign sum       = {high_sum[UPPER-1:0], low_sum[HALF-1:0]};
    assign carry_mid = low_sum[HALF];
    assign carry_top = high_sum[UPPER];
endmodule

// File: rtl/imm_alu.sv
module imm_alu
    import imm_alu_pkg::*;
#(
    parameter int W  = 64,
    parameter int IW = 16,
    parameter int SH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    op_sel,
    input  logic [W-1:0]  reg_a,
    input  logic [IW-1:0] imm,
    output logic          out_valid,
    output logic [W-1:0]  result,
    output logic [1:0]    carry,
    output logic          carry_we
);
    localparam int HALF = W / 2;

    typedef enum logic {ST_HOLD = 1'b0, ST_CAPTURE = 1'b1} cap_e;

    logic [W-1:0] opnd_x, opnd_y, sum;
    logic         carry_in, wr_carry, carry_mid, carry_top;
    cap_e         cap_state;

    imm_operand_gen #(.W(W), .IW(IW), .SH(SH)) u_opnd (
        .op_sel   (op_sel),
        .reg_a    (reg_a),
        .imm      (imm),
        .opnd_x   (opnd_x),
        .opnd_y   (opnd_y),
        .carry_in (carry_in),
        .wr_carry (wr_carry)
    );

    split_adder #(.W(W), .HALF(HALF)) u_add (
        .opnd_x    (opnd_x),
        .opnd_y    (opnd_y),
        .carry_in  (carry_in),
        .sum       (sum),
        .carry_mid (carry_mid),
        .carry_top (carry_top)
    );

    assign cap_state = in_valid ? ST_CAPTURE : ST_HOLD;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            carry     <= 2'b00;
            carry_we  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            unique case (cap_state)
                ST_CAPTURE: begin
                    result   <= sum;
                    carry    <= wr_carry ? {carry_mid, carry_top} : 2'b00;
                    carry_we <= wr_carry;
                end
                ST_HOLD: begin
                    result   <= result;
                    carry    <= carry;
                    carry_we <= carry_we;
                end
            endcase
        end
    end

    // R8: strobe delay
    a_r8_valid_delay: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> out_valid == $past(in_valid));
    // R8: outputs held while idle
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result) && $stable(carry) && $stable(carry_we));
    // R6: write-enable only for subtract-from
    a_r6_we_subfrom: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> carry_we == ($past(op_sel) == OP_SUB_FROM));
    // R6: carry field zero when not written
    a_r6_carry_quiet: assert property (@(posedge clk) disable iff (rst)
        !carry_we |-> carry == 2'b00);
    // R7: reserved code yields zeros
    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_sel == OP_RESERVED |=> result == '0 && carry == 2'b00);
    // R9: reset clears strobe
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> !out_valid && !carry_we);
endmodule

// File: tb/tb_imm_alu.sv
module tb_imm_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [63:0] reg_a = '0;
    logic [15:0] imm = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [1:0]  carry;
    logic        carry_we;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [1:0]  op;
        logic [63:0] res;
        logic [1:0]  cy;
        logic        we;
    } exp_t;

    exp_t sb[$];
    exp_t last_exp;

    always #10 clk = ~clk;

    imm_alu dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .reg_a(reg_a), .imm(imm), .out_valid(out_valid), .result(result),
        .carry(carry), .carry_we(carry_we)
    );

    function automatic exp_t model(input logic [1:0] op, input logic [63:0] a,
                                   input logic [15:0] im);
        exp_t e;
        logic [63:0] se;
        logic [64:0] full;
        logic [32:0] low;
        se = {{48{im[15]}}, im};
        e.op = op; e.res = '0; e.cy = 2'b00; e.we = 1'b0;
        case (op)
            2'b00: e.res = a + se;
            2'b01: e.res = a + {se[47:0], 16'h0000};
            2'b10: begin
                full = {1'b0, ~a} + {1'b0, se} + 65'd1;
                low  = {1'b0, ~a[31:0]} + {1'b0, se[31:0]} + 33'd1;
                e.res = full[63:0];
                e.cy  = {low[32], full[64]};
                e.we  = 1'b1;
            end
            default: ;
        endcase
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [63:0] a,
                         input logic [15:0] im);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; reg_a = a; imm = im;
        sb.push_back(model(op, a, im));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Monitor: samples 5 ns after each rising edge
    initial begin
        exp_t e;
        string rq;
        last_exp.res = '0; last_exp.cy = 2'b00; last_exp.we = 1'b0; last_exp.op = 2'b00;
        forever begin
            @(posedge clk);
            #5;
            if (!rst) begin
                check(out_valid == in_valid, "R8 valid delay", {63'd0, out_valid}, {63'd0, in_valid});
                if (out_valid) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R8 unexpected output", 64'd1, 64'd0);
                    end else begin
                        e = sb.pop_front();
                        case (e.op)
                            2'b00: rq = "R1 add imm";
                            2'b01: rq = "R2 add shifted";
                            2'b10: rq = "R3 subtract-from";
                            default: rq = "R7 reserved";
                        endcase
                        check(result == e.res, rq, result, e.res);
                        check(carry[0] == e.cy[0], "R4 carry63", {63'd0, carry[0]}, {63'd0, e.cy[0]});
                        check(carry[1] == e.cy[1], "R5 carry31", {63'd0, carry[1]}, {63'd0, e.cy[1]});
                        check(carry_we == e.we, "R6 carry_we", {63'd0, carry_we}, {63'd0, e.we});
                        last_exp = e;
                    end
                end else begin
                    check(result == last_exp.res && carry == last_exp.cy && carry_we == last_exp.we,
                          "R8 hold", result, last_exp.res);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 64'd0, 64'd1);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #5;
        // R9: reset state
        check(out_valid == 1'b0 && result == '0 && carry == 2'b00 && carry_we == 1'b0,
              "R9 reset", result, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        idle(2);
        // R1 edges
        drive(2'b00, 64'd0, 16'h0000);
        drive(2'b00, 64'd0, 16'h8000);
        drive(2'b00, '1, 16'h7FFF);
        drive(2'b00, '1, 16'h0001);
        // R2 edges
        drive(2'b01, 64'd0, 16'h8000);
        drive(2'b01, '1, 16'h7FFF);
        drive(2'b01, 64'h0123_4567_89AB_CDEF, 16'h0000);
        // R3/R4/R5 edges and carry splits
        drive(2'b10, 64'd0, 16'h0000);                   // both carries
        drive(2'b10, '1, 16'h0000);                      // neither
        drive(2'b10, 64'hFFFF_FFFF_0000_0000, 16'h0000); // only bit-31 carry
        drive(2'b10, 64'h0000_0000_FFFF_FFFF, 16'h8000); // only bit-63 carry
        drive(2'b10, 64'd0, 16'h7FFF);
        drive(2'b10, '1, 16'h8000);
        // R7 reserved
        drive(2'b11, '1, 16'h7FFF);
        idle(3);
        // R8 hold after subtract then idle
        drive(2'b10, 64'd5, 16'h0003);
        idle(2);
        drive(2'b00, 64'd7, 16'hFFFF);
        // random mix with idle gaps
        for (int i = 0; i < 300; i++) begin
            drive(2'($urandom_range(0, 3)), {$urandom, $urandom}, 16'($urandom));
            if (($urandom % 4) == 0) idle(1);
        end
        idle(3);
        // R9: reset mid-stream clears outputs
        drive(2'b10, 64'd0, 16'h0000);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        void'(sb.pop_front());
        @(negedge clk);
        check(out_valid == 1'b0 && carry_we == 1'b0 && result == '0, "R9 reset clears", result, 64'd0);
        rst = 1'b0;
        last_exp.res = '0; last_exp.cy = 2'b00; last_exp.we = 1'b0;
        idle(2);
        done = 1'b1;
        summary();
    end
endmodule